// File: doc/BRIEF.md
# VCO Sub-Band Calibration Engine

This block chooses the coarse band of a wideband switched-capacitor oscillator before the phase-locked loop closes. It tries band codes one bit at a time, most significant bit first. For each trial code it measures how many oscillator cycles pass during a fixed window of reference cycles. It then compares that figure with the count the requested division ratio implies. The expected count comes from the integer part of the ratio together with its four leading fractional bits. A band is therefore judged against the fractional target rather than the integer part alone, and the band error left over is at most one sixteenth of the reference frequency.

The oscillator side supplies a free-running Gray-coded cycle counter. The engine brings that counter into the reference domain through two flops and converts it to binary. A measurement is the difference between two snapshots taken a full window apart, computed modulo the counter width. A single start pulse runs the whole search in 160 reference cycles: eight steps of 20 cycles each. Each step allows settling, then a 16-cycle window, then the decision. When the search ends, the engine raises a one-cycle done pulse and holds the chosen code until the next start.

Top module: `vbc_band_cal`

## Requirements
- R1: While reset is asserted and after it is released, `band` is 0 and `busy` and `done` are low until a start is accepted.
- R2: A start seen while idle raises `busy` at the next clock edge with `band` = 8'h80, and `busy` then stays high for exactly 160 cycles.
- R3: `done` is high for exactly one cycle, in the first cycle in which `busy` is low again after a search.
- R4: The final code is the largest band whose measured count over 16 reference cycles is strictly below the expected count, or 0 if no band qualifies. A trial bit is kept when the count is below the expected count and cleared otherwise.
- R5: The expected count is `ratio_int`*16 + `ratio_frac_msb`: the ratio in sixteenths of the reference, with the four fractional bits as the low nibble.
- R6: The oscillator counter is 12-bit Gray code and free running. The result does not depend on the counter's starting value, including when the counter wraps during a window.
- R7: A start seen while `busy` is high has no effect on the search or its result.
- R8: Once done, `band` keeps its value until the next accepted start, whatever the ratio inputs do.
- R9: The ratio is captured when the start is accepted. Changes to `ratio_int` or `ratio_frac_msb` during a search do not alter its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Begin a calibration (sampled while idle) |
| ratio_int | input | 8 | Integer part of the division ratio |
| ratio_frac_msb | input | 4 | Four leading fractional bits of the ratio |
| vco_cnt_gray | input | 12 | Free-running Gray-coded oscillator cycle count, asynchronous |
| band | output | 8 | Band select code, trial value during a search |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse at the end of a search |

## Verification
The hardest situation to reach from the ports is a tie or near tie between a band's count and the target. In that case a single miscounted cycle in the window moves the result by one code. The bench models the oscillator as a phase accumulator whose rate is an exact linear function of the band code. For every band on the boundary it places the target exactly on that band's count and one above it. This makes an off-by-one window length, a one-cycle snapshot skew, or an inverted comparison visible. A sweep over the whole 12-bit target range, runs started from a counter offset just below wrap, and start pulses and ratio changes injected mid-search cover the remaining cases.

// File: rtl/vbc_pkg.sv
package vbc_pkg;
  typedef enum logic {
    CAL_IDLE = 1'b0,
    CAL_RUN  = 1'b1
  } cal_state_e;
endpackage

// File: rtl/vbc_gray_sync.sv
// Two-flop synchroniser for a Gray-coded count, followed by Gray to binary.
module vbc_gray_sync #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_async,
  output logic [W-1:0] bin
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_async;
      sync_q <= meta_q;
    end
  end

  assign bin[W-1] = sync_q[W-1];
  for (genvar i = W - 2; i >= 0; i--) begin : g_g2b
    assign bin[i] = bin[i+1] ^ sync_q[i];
  end
endmodule

// File: rtl/vbc_target_dec.sv
// Expected oscillator count per window, from the integer ratio and fraction MSBs.
module vbc_target_dec #(
  parameter int INT_W    = 8,
  parameter int FRAC_USE = 4,
  parameter int WIN_LOG2 = 4,
  parameter int CNT_W    = 12
) (
  input  logic [INT_W-1:0]    ratio_int,
  input  logic [FRAC_USE-1:0] ratio_frac_msb,
  output logic [CNT_W-1:0]    target
);
  localparam int CAT_W = INT_W + FRAC_USE;
  localparam int SHIFT = WIN_LOG2 - FRAC_USE;

  logic [CAT_W-1:0] ratio_cat;

  assign ratio_cat = {ratio_int, ratio_frac_msb};
  assign target    = CNT_W'(ratio_cat) << SHIFT;
endmodule

// File: rtl/vbc_window_meter.sv
// Snapshots the synchronised count at window open and forms the difference at close.
module vbc_window_meter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_bin,
  input  logic             snap_open,
  input  logic             snap_close,
  output logic [CNT_W-1:0] meas
);
  logic [CNT_W-1:0] open_q, open_d;
  logic [CNT_W-1:0] meas_q, meas_d;

  always_comb begin
    open_d = open_q;
    meas_d = meas_q;
    if (snap_open)  open_d = cnt_bin;
    if (snap_close) meas_d = cnt_bin - open_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= '0;
      meas_q <= '0;
    end else begin
      if (snap_open)  open_q <= open_d;
      if (snap_close) meas_q <= meas_d;
    end
  end

  assign meas = meas_q;
endmodule

// File: rtl/vbc_sar_ctrl.sv
// Successive-approximation search over the band code, one step per window.
module vbc_sar_ctrl
  import vbc_pkg::*;
#(
  parameter int BAND_W      = 8,
  parameter int CNT_W       = 12,
  parameter int WIN_LOG2    = 4,
  parameter int SETTLE      = 2,
  parameter bit UP_WHEN_LOW = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  target_in,
  input  logic [CNT_W-1:0]  meas,
  output logic              snap_open,
  output logic              snap_close,
  output logic [BAND_W-1:0] band,
  output logic              busy,
  output logic              done
);
  localparam int WIN      = 1 << WIN_LOG2;
  localparam int STEP     = SETTLE + WIN + 2;
  localparam int PH_W     = $clog2(STEP);
  localparam int IDX_W    = $clog2(BAND_W);
  localparam int OPEN_PH  = SETTLE;
  localparam int CLOSE_PH = SETTLE + WIN;
  localparam int DEC_PH   = STEP - 1;

  cal_state_e        state_q, state_d;
  logic [PH_W-1:0]   ph_q, ph_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [BAND_W-1:0] band_q, band_d;
  logic [CNT_W-1:0]  tgt_q, tgt_d;
  logic              done_q, done_d;
  logic              accept;
  logic              at_dec;
  logic              below;
  logic              keep_bit;

  assign accept   = (state_q == CAL_IDLE) && start;
  assign at_dec   = (state_q == CAL_RUN) && (ph_q == PH_W'(DEC_PH));
  assign below    = meas < tgt_q;
  assign keep_bit = UP_WHEN_LOW ? below : !below;

  assign snap_open  = (state_q == CAL_RUN) && (ph_q == PH_W'(OPEN_PH));
  assign snap_close = (state_q == CAL_RUN) && (ph_q == PH_W'(CLOSE_PH));

  always_comb begin
    state_d = state_q;
    ph_d    = ph_q;
    idx_d   = idx_q;
    band_d  = band_q;
    tgt_d   = tgt_q;
    done_d  = 1'b0;
    if (accept) begin
      state_d = CAL_RUN;
      ph_d    = '0;
      idx_d   = IDX_W'(BAND_W - 1);
      band_d  = '0;
      band_d[BAND_W-1] = 1'b1;
      tgt_d   = target_in;
    end else if (state_q == CAL_RUN) begin
      if (at_dec) begin
        ph_d = '0;
        if (!keep_bit) band_d[idx_q] = 1'b0;
        if (idx_q == '0) begin
          state_d = CAL_IDLE;
          done_d  = 1'b1;
        end else begin
          idx_d = idx_q - IDX_W'(1);
          band_d[idx_d] = 1'b1;
        end
      end else begin
        ph_d = ph_q + PH_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CAL_IDLE;
      ph_q    <= '0;
      idx_q   <= '0;
      band_q  <= '0;
      tgt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
      idx_q   <= idx_d;
      band_q  <= band_d;
      if (accept) tgt_q <= tgt_d;
      done_q  <= done_d;
    end
  end

  assign band = band_q;
  assign busy = (state_q == CAL_RUN);
  assign done = done_q;
endmodule

// File: rtl/vbc_band_cal.sv
module vbc_band_cal #(
  parameter int BAND_W      = 8,
  parameter int INT_W       = 8,
  parameter int FRAC_USE    = 4,
  parameter int WIN_LOG2    = 4,
  parameter int SETTLE      = 2,
  parameter bit UP_WHEN_LOW = 1'b1,
  parameter int CNT_W       = INT_W + WIN_LOG2
) (
  input  logic                clk_ref,
  input  logic                rst_n,
  input  logic                start,
  input  logic [INT_W-1:0]    ratio_int,
  input  logic [FRAC_USE-1:0] ratio_frac_msb,
  input  logic [CNT_W-1:0]    vco_cnt_gray,
  output logic [BAND_W-1:0]   band,
  output logic                busy,
  output logic                done
);
  logic [CNT_W-1:0] cnt_bin;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] meas;
  logic             snap_open;
  logic             snap_close;

  vbc_gray_sync #(.W(CNT_W)) u_sync (
    .clk        (clk_ref),
    .rst_n      (rst_n),
    .gray_async (vco_cnt_gray),
    .bin        (cnt_bin)
  );

  vbc_target_dec #(
    .INT_W    (INT_W),
    .FRAC_USE (FRAC_USE),
    .WIN_LOG2 (WIN_LOG2),
    .CNT_W    (CNT_W)
  ) u_dec (
    .ratio_int      (ratio_int),
    .ratio_frac_msb (ratio_frac_msb),
    .target         (target)
  );

  vbc_window_meter #(.CNT_W(CNT_W)) u_meter (
    .clk        (clk_ref),
    .rst_n      (rst_n),
    .cnt_bin    (cnt_bin),
    .snap_open  (snap_open),
    .snap_close (snap_close),
    .meas       (meas)
  );

  vbc_sar_ctrl #(
    .BAND_W      (BAND_W),
    .CNT_W       (CNT_W),
    .WIN_LOG2    (WIN_LOG2),
    .SETTLE      (SETTLE),
    .UP_WHEN_LOW (UP_WHEN_LOW)
  ) u_ctrl (
    .clk        (clk_ref),
    .rst_n      (rst_n),
    .start      (start),
    .target_in  (target),
    .meas       (meas),
    .snap_open  (snap_open),
    .snap_close (snap_close),
    .band       (band),
    .busy       (busy),
    .done       (done)
  );
endmodule

// File: rtl/vbc_band_cal_chk.sv
module vbc_band_cal_chk #(
  parameter int BAND_W   = 8,
  parameter int WIN_LOG2 = 4,
  parameter int SETTLE   = 2
) (
  input logic              clk_ref,
  input logic              rst_n,
  input logic              start,
  input logic [BAND_W-1:0] band,
  input logic              busy,
  input logic              done
);
  localparam int TOTAL = BAND_W * (SETTLE + (1 << WIN_LOG2) + 2);
  localparam logic [BAND_W-1:0] TRIAL = BAND_W'(1) << (BAND_W - 1);

  logic [15:0] busy_cnt;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) busy_cnt <= '0;
    else        busy_cnt <= busy ? busy_cnt + 16'd1 : 16'd0;
  end

  p_reset_quiet_r1: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  p_trial_msb_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (!busy && start) |=> (busy && band == TRIAL));

  p_busy_len_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == 16'(TOTAL)));

  p_done_single_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    done |=> !done);

  p_done_ends_busy_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_hold_idle_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (!busy && !start) |=> $stable(band));
endmodule

bind vbc_band_cal vbc_band_cal_chk #(
  .BAND_W   (BAND_W),
  .WIN_LOG2 (WIN_LOG2),
  .SETTLE   (SETTLE)
) u_chk (
  .clk_ref (clk_ref),
  .rst_n   (rst_n),
  .start   (start),
  .band    (band),
  .busy    (busy),
  .done    (done)
);

// File: tb/vbc_band_cal_tb.sv
`timescale 1ns/1ps
module vbc_band_cal_tb;
  localparam int BASE  = 600;
  localparam int SLOPE = 13;

  logic        clk_ref = 1'b0;
  logic        rst_n;
  logic        start;
  logic [7:0]  ratio_int;
  logic [3:0]  ratio_frac_msb;
  logic [11:0] vco_cnt_gray;
  logic [7:0]  band;
  logic        busy;
  logic        done;

  int n_checks = 0;
  int n_fail   = 0;

  logic [11:0] vbin  = 12'd0;
  logic [11:0] vofs  = 12'd0;
  int          vacc  = 0;

  always #2 clk_ref = ~clk_ref;

  vbc_band_cal u_dut (
    .clk_ref        (clk_ref),
    .rst_n          (rst_n),
    .start          (start),
    .ratio_int      (ratio_int),
    .ratio_frac_msb (ratio_frac_msb),
    .vco_cnt_gray   (vco_cnt_gray),
    .band           (band),
    .busy           (busy),
    .done           (done)
  );

  // Behavioural oscillator: BASE + SLOPE*band cycles per 16 reference cycles.
  always @(negedge clk_ref) begin
    vacc = vacc + BASE + SLOPE * int'(band);
    vbin = vbin + 12'(vacc >> 4);
    vacc = vacc & 15;
    vco_cnt_gray = (vbin + vofs) ^ ((vbin + vofs) >> 1);
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int exp_band(input int tgt);
    int r = 0;
    for (int c = 0; c < 256; c++)
      if (BASE + SLOPE * c < tgt) r = c;
    return r;
  endfunction

  // mode 0: plain, 1: start pulse and ratio change during the search
  task automatic run_cal(input int tgt, input int mode, input string tag);
    int k;
    int expb;
    expb = exp_band(tgt);
    @(negedge clk_ref);
    ratio_int      = 8'(tgt >> 4);
    ratio_frac_msb = 4'(tgt);
    start          = 1'b1;
    @(negedge clk_ref);
    start = 1'b0;
    k = 1;
    check(busy == 1'b1 && band == 8'h80, "R2 trial code at start", int'(band), 128);
    while (!done && k < 400) begin
      @(negedge clk_ref);
      k++;
      if (mode == 1 && k == 50) begin
        start          = 1'b1;
        ratio_int      = ~ratio_int;
        ratio_frac_msb = ~ratio_frac_msb;
      end
      if (mode == 1 && k == 51) start = 1'b0;
    end
    check(k == 161, "R2 busy length", k - 1, 160);
    check(!busy, "R3 busy low with done", int'(busy), 0);
    if (mode == 1)
      check(int'(band) == expb, "R7 R9 result under disturbance", int'(band), expb);
    else
      check(int'(band) == expb, tag, int'(band), expb);
    @(negedge clk_ref);
    check(!done, "R3 done single cycle", int'(done), 0);
    check(int'(band) == expb, "R8 band held after done", int'(band), expb);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    ratio_int = 8'd0;
    ratio_frac_msb = 4'd0;
    repeat (4) @(negedge clk_ref);
    check(band == 8'd0 && !busy && !done, "R1 state in reset", int'(band), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk_ref);
    check(band == 8'd0 && !busy && !done, "R1 state after reset", int'(band), 0);

    // R4 R5: boundary targets at and just above band counts
    for (int i = 0; i < 6; i++) begin
      int c;
      c = (i == 0) ? 0 : (i == 1) ? 1 : (i == 2) ? 127 : (i == 3) ? 128 : (i == 4) ? 254 : 255;
      run_cal(BASE + SLOPE * c, 0, "R4 tie target");
      run_cal(BASE + SLOPE * c + 1, 0, "R4 just above target");
    end
    run_cal(0, 0, "R4 target below all bands");
    run_cal(4095, 0, "R4 R5 maximum target");

    // R5 R4: sweep over the ratio range, all fraction nibbles exercised
    for (int t = 3; t < 4096; t += 13)
      run_cal(t, 0, "R5 R4 sweep");

    // R6: counter offset near wrap
    for (int j = 0; j < 4; j++) begin
      @(negedge clk_ref);
      vofs = 12'hFF0 - 12'(j * 37);
      run_cal(1000 + j * 611, 0, "R6 result with wrapped counter");
    end

    // R7 R9: start and ratio change during a search
    run_cal(1777, 1, "R7");
    run_cal(2500, 1, "R9");

    // R8: band held while ratio inputs wander
    begin
      logic [7:0] held;
      held = band;
      for (int j = 0; j < 30; j++) begin
        @(negedge clk_ref);
        ratio_int      = 8'(j * 29);
        ratio_frac_msb = 4'(j);
      end
      check(band == held, "R8 band stable in idle", int'(band), int'(held));
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule